// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block takes the core from its running state into one of four low-power states and back again. A one-cycle sleep request is accepted only when the sleep-enable input is high in that same cycle. The 3-bit mode code is latched at that point. Each mode gates its own set of clock domains: CPU, I/O, flash, ADC and the asynchronous timer. When the ADC is enabled, the two light modes also emit a single conversion-start pulse as they are entered.

While asleep, the block passes a vector of wake sources through a mask that depends on the mode. One level-sensitive line must be held for several consecutive cycles before it counts. In the timer-keepalive mode, the timer events also need both their own enable and the global interrupt enable.

When a wake is accepted from one of the light modes, the clocks come back on the next cycle. When it is accepted from one of the two deep modes, an oscillator-settling count runs first, and its length is chosen by a selector input. Reset-class sources skip or abort that count. A one-cycle acknowledge marks every return to the running state.

The FSM has three states:
- ST_ACTIVE: running, with all clocks on.
- ST_SLEEP: gated, and watching the wake sources.
- ST_STARTUP: gated, and counting the settling delay.

It has five transitions:
- enter: ST_ACTIVE to ST_SLEEP, on a request with enable set.
- wake_light: ST_SLEEP to ST_ACTIVE.
- wake_deep: ST_SLEEP to ST_STARTUP.
- settle_done: ST_STARTUP to ST_ACTIVE.
- reset_bypass: ST_SLEEP or ST_STARTUP to ST_ACTIVE, on a reset-class source.

Top module: `sleep_power_ctrl`

## Requirements
- R1: A sleep request with sleep_en low is ignored. All clocks stay enabled and no acknowledge is produced.
- R2: The mode code is latched on entry. Code 0 and codes 4 to 7 select idle. Idle gates only the CPU and flash clocks, and keeps I/O, ADC and async-timer clocks on.
- R3: Code 1 selects ADC noise reduction. It gates the CPU, I/O and flash clocks and keeps the ADC and async-timer clocks on.
- R4: On entry to idle or ADC noise reduction with adc_en high, adc_start is high for exactly the first sleeping cycle. It stays low for the other modes, and when adc_en is low.
- R5: The wake_src bit positions are: 0 external reset, 1 watchdog reset, 2 brown-out, 3 watchdog interrupt, 4 two-wire address match, 5 two-wire interrupt, 6 timer-2 overflow, 7 timer-2 compare, 8 ADC done, 9 memory ready, 10 upper external level, 11 lower external interrupt, 12 pin change, 13 comparator, 14 other interrupts. ADC noise reduction accepts bits 0 to 10 and 12.
- R6: Code 2 selects power-down. All five clocks are gated. It accepts only bits 0, 1, 2, 4, 10, 11 and 12.
- R7: Code 3 selects power-save. It acts as power-down, except that the async-timer clock follows t2_run. Bit 6 wakes only with t2_ovf_en and gie both high, and bit 7 only with t2_cmp_en and gie both high.
- R8: Idle accepts every bit, except bit 13 when comp_off is high.
- R9: A non-reset wake from power-down or power-save keeps every clock gated for 4 << (2*su_sel) cycles after the wake cycle. A wake from a light mode returns to running on the next edge.
- R10: Bit 10 wakes only when it has been high for 3 consecutive sleeping cycles.
- R11: A reset-class source (bits 0 to 2) in the sleeping or settling state returns the block to running at the next edge, with all clocks on.
- R12: wake_ack is high for exactly the first running cycle after each return to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to sleep |
| sleep_en | input | 1 | Sleep permitted |
| sleep_mode | input | 3 | Low-power mode code |
| adc_en | input | 1 | ADC enabled; permits the start pulse |
| comp_off | input | 1 | Comparator powered off; masks bit 13 in idle |
| t2_run | input | 1 | Timer 2 running; keeps the async clock on in power-save |
| t2_ovf_en | input | 1 | Timer-2 overflow wake enable |
| t2_cmp_en | input | 1 | Timer-2 compare wake enable |
| gie | input | 1 | Global interrupt enable |
| su_sel | input | 2 | Settling delay selector |
| wake_src | input | 15 | Wake source vector |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| clk_async_en | output | 1 | Async-timer clock enable |
| adc_start | output | 1 | ADC conversion-start pulse |
| wake_ack | output | 1 | Returned to running |

## Verification
The assertions assume three things about the inputs:
- sleep_req is a single-cycle pulse.
- su_sel, the qualifier enables and comp_off are stable while the block is asleep.
- The settling base delay is non-zero.

The stimulus obeys all three. Every request is raised for exactly one cycle. The mode, qualifiers and selector are set before the request and changed only after the acknowledge. Wake sources are driven between edges and released once the acknowledge has been seen, or once a fixed no-wake window has closed.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int WAKE_W    = 15;
    localparam int W_EXTRST  = 0;
    localparam int W_WDRST   = 1;
    localparam int W_BOR     = 2;
    localparam int W_WDINT   = 3;
    localparam int W_TWIADR  = 4;
    localparam int W_TWIINT  = 5;
    localparam int W_T2OVF   = 6;
    localparam int W_T2CMP   = 7;
    localparam int W_ADCDONE = 8;
    localparam int W_MEMRDY  = 9;
    localparam int W_LVLHI   = 10;
    localparam int W_EXTLO   = 11;
    localparam int W_PCINT   = 12;
    localparam int W_COMP    = 13;
    localparam int W_OTHER   = 14;

    typedef enum logic [1:0] {ST_ACTIVE, ST_SLEEP, ST_STARTUP} slp_state_t;
    typedef enum logic [1:0] {MD_IDLE, MD_ADCNR, MD_PDOWN, MD_PSAVE} slp_mode_t;

    localparam logic [WAKE_W-1:0] RST_CLASS =
        (WAKE_W'(1) << W_EXTRST) | (WAKE_W'(1) << W_WDRST) | (WAKE_W'(1) << W_BOR);

    function automatic slp_mode_t decode_mode(input logic [2:0] code);
        unique case (code)
            3'd1:    return MD_ADCNR;
            3'd2:    return MD_PDOWN;
            3'd3:    return MD_PSAVE;
            default: return MD_IDLE;
        endcase
    endfunction

    function automatic logic is_deep(input slp_mode_t m);
        return (m == MD_PDOWN) || (m == MD_PSAVE);
    endfunction

    function automatic logic [WAKE_W-1:0] base_mask(input slp_mode_t m, input logic comp_off);
        logic [WAKE_W-1:0] msk;
        msk = '0;
        unique case (m)
            MD_IDLE: begin
                msk = '1;
                msk[W_COMP] = ~comp_off;
            end
            MD_ADCNR: begin
                msk = RST_CLASS;
                msk[W_WDINT]   = 1'b1;
                msk[W_TWIADR]  = 1'b1;
                msk[W_TWIINT]  = 1'b1;
                msk[W_T2OVF]   = 1'b1;
                msk[W_T2CMP]   = 1'b1;
                msk[W_ADCDONE] = 1'b1;
                msk[W_MEMRDY]  = 1'b1;
                msk[W_LVLHI]   = 1'b1;
                msk[W_PCINT]   = 1'b1;
            end
            default: begin
                msk = RST_CLASS;
                msk[W_TWIADR] = 1'b1;
                msk[W_LVLHI]  = 1'b1;
                msk[W_EXTLO]  = 1'b1;
                msk[W_PCINT]  = 1'b1;
            end
        endcase
        return msk;
    endfunction

endpackage

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
    import slp_pkg::*;
#(
    parameter int LVL_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sleep,
    input  logic              in_startup,
    input  slp_mode_t         mode,
    input  logic              comp_off,
    input  logic              t2_ovf_en,
    input  logic              t2_cmp_en,
    input  logic              gie,
    input  logic [WAKE_W-1:0] src,
    output logic              wake_hit,
    output logic              rst_hit
);
    localparam int LCW = $clog2(LVL_HOLD + 1);

    logic [LCW-1:0]    lvl_cnt;
    logic              lvl_ok;
    logic [WAKE_W-1:0] msk;
    logic [WAKE_W-1:0] eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lvl_cnt <= '0;
        else if (!in_sleep || !src[W_LVLHI])
            lvl_cnt <= '0;
        else if (lvl_cnt != LCW'(LVL_HOLD - 1))
            lvl_cnt <= lvl_cnt + 1'b1;
    end

    assign lvl_ok = src[W_LVLHI] && (lvl_cnt == LCW'(LVL_HOLD - 1));

    always_comb begin
        msk = base_mask(mode, comp_off);
        if (mode == MD_PSAVE) begin
            msk[W_T2OVF] = t2_ovf_en & gie;
            msk[W_T2CMP] = t2_cmp_en & gie;
        end
        eff = src;
        eff[W_LVLHI] = lvl_ok;
    end

    assign wake_hit = in_sleep && |(eff & msk);
    assign rst_hit  = (in_sleep || in_startup) && |(src & msk & RST_CLASS);

    generate
        if (LVL_HOLD > 1) begin : g_lvl_chk
            p_lvl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (in_sleep && lvl_ok) |-> $past(src[W_LVLHI]))
                else $error("level wake without hold");
        end
    endgenerate

endmodule

// File: rtl/slp_startup_timer.sv
module slp_startup_timer #(
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 2,
    parameter int SU_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             abort,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dly;

    assign dly = CNT_W'(SU_BASE) << (2 * sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= dly;
        else if (abort)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CNT_W'(1)) && !abort;

    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !load && !abort) |=> (cnt == CNT_W'($past(cnt) - 1'b1)))
        else $error("settling counter skipped");

endmodule

// File: rtl/sleep_power_ctrl.sv
module sleep_power_ctrl
    import slp_pkg::*;
#(
    parameter int LVL_HOLD = 3,
    parameter int CNT_W    = 16,
    parameter int SEL_W    = 2,
    parameter int SU_BASE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              sleep_en,
    input  logic [2:0]        sleep_mode,
    input  logic              adc_en,
    input  logic              comp_off,
    input  logic              t2_run,
    input  logic              t2_ovf_en,
    input  logic              t2_cmp_en,
    input  logic              gie,
    input  logic [SEL_W-1:0]  su_sel,
    input  logic [14:0]       wake_src,
    output logic              clk_cpu_en,
    output logic              clk_io_en,
    output logic              clk_flash_en,
    output logic              clk_adc_en,
    output logic              clk_async_en,
    output logic              adc_start,
    output logic              wake_ack
);
    slp_state_t state_q, state_d;
    slp_mode_t  mode_q, mode_req;
    logic       enter, wake_hit, rst_hit, tmr_load, tmr_done;
    logic       adc_start_q, wake_ack_q;

    assign mode_req = decode_mode(sleep_mode);
    assign enter    = (state_q == ST_ACTIVE) && sleep_req && sleep_en;
    assign tmr_load = (state_q == ST_SLEEP) && wake_hit && !rst_hit && is_deep(mode_q);

    slp_wake_filter #(.LVL_HOLD(LVL_HOLD)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_sleep   (state_q == ST_SLEEP),
        .in_startup (state_q == ST_STARTUP),
        .mode       (mode_q),
        .comp_off   (comp_off),
        .t2_ovf_en  (t2_ovf_en),
        .t2_cmp_en  (t2_cmp_en),
        .gie        (gie),
        .src        (wake_src),
        .wake_hit   (wake_hit),
        .rst_hit    (rst_hit)
    );

    slp_startup_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SU_BASE(SU_BASE)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .sel   (su_sel),
        .abort (rst_hit),
        .done  (tmr_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (enter) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (rst_hit)       state_d = ST_ACTIVE;
                else if (wake_hit) state_d = is_deep(mode_q) ? ST_STARTUP : ST_ACTIVE;
            end
            ST_STARTUP: if (rst_hit || tmr_done) state_d = ST_ACTIVE;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_ACTIVE;
            mode_q      <= MD_IDLE;
            adc_start_q <= 1'b0;
            wake_ack_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            if (enter) mode_q <= mode_req;
            adc_start_q <= enter && adc_en && !is_deep(mode_req);
            wake_ack_q  <= (state_q != ST_ACTIVE) && (state_d == ST_ACTIVE);
        end
    end

    always_comb begin
        clk_cpu_en   = 1'b1;
        clk_io_en    = 1'b1;
        clk_flash_en = 1'b1;
        clk_adc_en   = 1'b1;
        clk_async_en = 1'b1;
        if (state_q != ST_ACTIVE) begin
            clk_cpu_en   = 1'b0;
            clk_flash_en = 1'b0;
            unique case (mode_q)
                MD_IDLE:  ;
                MD_ADCNR: clk_io_en = 1'b0;
                MD_PDOWN: begin
                    clk_io_en    = 1'b0;
                    clk_adc_en   = 1'b0;
                    clk_async_en = 1'b0;
                end
                MD_PSAVE: begin
                    clk_io_en    = 1'b0;
                    clk_adc_en   = 1'b0;
                    clk_async_en = t2_run;
                end
                default: ;
            endcase
        end
    end

    assign adc_start = adc_start_q;
    assign wake_ack  = wake_ack_q;

    p_ignore_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && sleep_req && !sleep_en) |=> (clk_cpu_en && !wake_ack))
        else $error("request without enable was taken");

    p_adc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start)
        else $error("conversion start longer than one cycle");

    p_pd_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && mode_q == MD_PDOWN) |-> !(clk_io_en || clk_adc_en || clk_async_en))
        else $error("clock running in power-down");

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP && rst_hit) |=> (clk_cpu_en && wake_ack))
        else $error("reset-class source did not abort settling");

    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |=> !wake_ack)
        else $error("acknowledge longer than one cycle");

endmodule

// File: tb/sim_sleep_power_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_power_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0, sleep_en = 1'b0;
    logic [2:0]  sleep_mode = 3'd0;
    logic        adc_en = 1'b0, comp_off = 1'b0, t2_run = 1'b0;
    logic        t2_ovf_en = 1'b0, t2_cmp_en = 1'b0, gie = 1'b0;
    logic [1:0]  su_sel = 2'd0;
    logic [14:0] wake_src = '0;
    logic        clk_cpu_en, clk_io_en, clk_flash_en, clk_adc_en, clk_async_en;
    logic        adc_start, wake_ack;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sleep_power_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
        .sleep_mode(sleep_mode), .adc_en(adc_en), .comp_off(comp_off), .t2_run(t2_run),
        .t2_ovf_en(t2_ovf_en), .t2_cmp_en(t2_cmp_en), .gie(gie), .su_sel(su_sel),
        .wake_src(wake_src), .clk_cpu_en(clk_cpu_en), .clk_io_en(clk_io_en),
        .clk_flash_en(clk_flash_en), .clk_adc_en(clk_adc_en), .clk_async_en(clk_async_en),
        .adc_start(adc_start), .wake_ack(wake_ack)
    );

    // {mode[2:0], src[3:0], qual{comp_off,gie,ovf_en,cmp_en}[3:0], latency[4:0]}; latency 0 = no wake
    localparam logic [15:0] VEC [0:17] = '{
        {3'd0, 4'd14, 4'b0000, 5'd1},
        {3'd0, 4'd13, 4'b0000, 5'd1},
        {3'd0, 4'd13, 4'b1000, 5'd0},
        {3'd5, 4'd11, 4'b0000, 5'd1},
        {3'd1, 4'd8,  4'b0000, 5'd1},
        {3'd1, 4'd14, 4'b0000, 5'd0},
        {3'd1, 4'd11, 4'b0000, 5'd0},
        {3'd1, 4'd6,  4'b0000, 5'd1},
        {3'd2, 4'd11, 4'b0000, 5'd5},
        {3'd2, 4'd8,  4'b0000, 5'd0},
        {3'd2, 4'd1,  4'b0000, 5'd1},
        {3'd2, 4'd6,  4'b0111, 5'd0},
        {3'd3, 4'd6,  4'b0110, 5'd5},
        {3'd3, 4'd6,  4'b0010, 5'd0},
        {3'd3, 4'd7,  4'b0101, 5'd5},
        {3'd3, 4'd7,  4'b0110, 5'd0},
        {3'd3, 4'd12, 4'b0000, 5'd5},
        {3'd7, 4'd5,  4'b0000, 5'd1}
    };

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic enter(input logic [2:0] m);
        sleep_mode = m;
        sleep_en   = 1'b1;
        sleep_req  = 1'b1;
        step();
        sleep_req  = 1'b0;
    endtask

    task automatic wait_ack(input int lim, output int lat);
        lat = 0;
        for (int i = 1; i <= lim; i++) begin
            step();
            if (wake_ack && lat == 0) lat = i;
            if (lat != 0) break;
        end
    endtask

    task automatic bail_out();
        wake_src = 15'h1;
        step();
        wake_src = '0;
        chk("R11", int'(wake_ack), 1, "reset-class exit");
    endtask

    function automatic int norm(input logic [2:0] m);
        return (m > 3) ? 0 : int'(m);
    endfunction

    function automatic int exp_clk(input int m, input logic run);
        unique case (m)
            0:       return 5'b01011;
            1:       return 5'b00011;
            2:       return 5'b00000;
            default: return {4'b0000, run};
        endcase
    endfunction

    function automatic string tag(input int m);
        unique case (m)
            0:       return "R8";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string clk_tag(input int m);
        unique case (m)
            0:       return "R2";
            1:       return "R3";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int m;
        repeat (3) @(posedge clk);
        #1;
        chk("R2", {clk_cpu_en, clk_io_en, clk_flash_en, clk_adc_en, clk_async_en}, 5'b11111, "clocks in reset");
        chk("R12", int'(wake_ack), 0, "ack in reset");
        rst_n = 1'b1;
        step();
        chk("R4", int'(adc_start), 0, "start pulse after reset");

        for (int k = 0; k < 18; k++) begin
            m         = norm(VEC[k][15:13]);
            comp_off  = VEC[k][8];
            gie       = VEC[k][7];
            t2_ovf_en = VEC[k][6];
            t2_cmp_en = VEC[k][5];
            t2_run    = 1'b1;
            adc_en    = 1'b1;
            su_sel    = 2'd0;
            enter(VEC[k][15:13]);
            chk(clk_tag(m), {clk_cpu_en, clk_io_en, clk_flash_en, clk_adc_en, clk_async_en},
                exp_clk(m, 1'b1), "clock enables asleep");
            chk("R4", int'(adc_start), (m < 2) ? 1 : 0, "start pulse on entry");
            wake_src = 15'h1 << VEC[k][12:9];
            wait_ack(20, lat);
            wake_src = '0;
            chk((m >= 2 && VEC[k][4:0] > 1) ? "R9" : tag(m), lat, int'(VEC[k][4:0]), "wake latency");
            if (lat == 0) bail_out();
        end

        // R1: request without enable
        sleep_en = 1'b0; sleep_mode = 3'd2; sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R1", int'(clk_cpu_en), 1, "cpu clock after refused request");
        step();
        chk("R1", int'(clk_io_en) + int'(wake_ack), 1, "still running, no ack");

        // R4: adc_en low, then single-pulse check
        adc_en = 1'b0;
        enter(3'd1);
        chk("R4", int'(adc_start), 0, "no start with ADC disabled");
        bail_out();
        step();
        chk("R12", int'(wake_ack), 0, "ack drops after one cycle");
        adc_en = 1'b1;
        enter(3'd0);
        step();
        chk("R4", int'(adc_start), 0, "start pulse lasts one cycle");
        bail_out();

        // R10: level hold
        enter(3'd0);
        wake_src = 15'h1 << 10;
        step();
        step();
        wake_src = '0;
        lat = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            if (wake_ack) lat = 1;
        end
        chk("R10", lat, 0, "two-cycle level ignored");
        wake_src = 15'h1 << 10;
        wait_ack(10, lat);
        wake_src = '0;
        chk("R10", lat, 3, "three-cycle level wakes");

        // R9: longer settling
        su_sel = 2'd2;
        enter(3'd2);
        wake_src = 15'h1 << 11;
        step();
        wake_src = '0;
        chk("R9", int'(clk_cpu_en) + int'(clk_io_en), 0, "clocks gated while settling");
        wait_ack(100, lat);
        chk("R9", lat, 64, "settling length sel=2");

        // R11: abort settling
        su_sel = 2'd3;
        enter(3'd3);
        wake_src = 15'h1 << 11;
        step();
        wake_src = '0;
        repeat (10) step();
        chk("R11", int'(wake_ack), 0, "still settling");
        wake_src = 15'h1 << 2;
        step();
        wake_src = '0;
        chk("R11", int'(wake_ack) + int'(clk_cpu_en), 2, "abort to running");

        // R7: timer not running in power-save
        t2_run = 1'b0;
        enter(3'd3);
        chk("R7", int'(clk_async_en), 0, "async clock off without timer");
        bail_out();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule